// File: doc/BRIEF.md
# General-Purpose I/O Port with Register Bus

This block is one 32-pin general-purpose I/O port that sits behind a simple memory-mapped register bus. Software writes an output data register and a per-pin direction register. It can also set individual output bits through a set-output register, which can only be written. The port drives a pad value vector and a pad output-enable vector. It brings the pad inputs back through a synchronizer so that they can be read as an input data register.

Every access is decoded inside a small address window. An access to a defined register completes in the cycle it is presented, with no wait state. Any other address in the window gets a bus error. This covers both the undefined word offsets and the offsets that are not word-aligned. The error is signalled one cycle later, so an error access costs exactly one wait state, and an errored access leaves every register as it was.

The access controller is a two-state machine. `ST_IDLE` accepts requests: a hit is answered at once and the machine stays in `ST_IDLE`, while a miss takes the transition `ST_IDLE -> ST_ERR_WAIT`. `ST_ERR_WAIT` raises ready together with the error flag, then takes the transition `ST_ERR_WAIT -> ST_IDLE` without a condition. The requester holds valid, write, address and write data steady until it sees ready.

Top module: `gpio_port`

## Requirements
- R1: After reset the output data and direction registers are zero, so `pad_out` and `pad_oe` are all zeros and both registers read back as zero.
- R2: The output data register sits at byte offset 0x00. It can be read and written, and `pad_out` always equals it.
- R3: The direction register sits at byte offset 0x14. It can be read and written, and `pad_oe` equals it: a 1 bit makes that pin an output and a 0 bit makes it an input.
- R4: The set-output register sits at byte offset 0x04. Writing it sets each output data bit whose written bit is 1 and leaves the bits written 0 unchanged. Reading it always returns zero.
- R5: The input data register sits at byte offset 0x10 and can only be read. It returns `pad_in` after two rising clock edges of synchronization, so a change made just after edge k is first seen after edge k+2. A write to it completes without error and changes nothing.
- R6: An access to offset 0x00, 0x04, 0x10 or 0x14 raises `bus_ready` in the same cycle as `bus_valid`, with `bus_error` low (zero wait states).
- R7: An access to any other offset in the window, or to an offset whose two low bits are not zero, keeps `bus_ready` low for one cycle. In the next cycle it raises `bus_ready` and `bus_error` together, with `bus_rdata` equal to zero (one wait state).
- R8: An errored write changes neither the output data register nor the direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access request, held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte offset within the port window |
| bus_wdata | input | NPIN (32) | Write data |
| bus_rdata | output | NPIN (32) | Read data, valid while `bus_ready` is high on a read |
| bus_ready | output | 1 | Access completes in this cycle |
| bus_error | output | 1 | Access is answered with a bus error (only with `bus_ready`) |
| pad_in | input | NPIN (32) | Asynchronous pad input levels |
| pad_out | output | NPIN (32) | Pad output values |
| pad_oe | output | NPIN (32) | Pad output enables, 1 = drive |

## Verification
The output data register is written with mixed bit patterns and then changed through the set-output register. A set word with a different set of 1 bits shows whether bits written as 0 are left alone, and a set word of all zeros must change nothing. Pad input words are read on three reads in a row after a change, which shows that the synchronizer delays the change by exactly two edges and not by one or three. Error addresses cover undefined aligned offsets, the unused top of the window and misaligned offsets next to valid registers. A misaligned offset next to a register shows whether the decoder ignores the low address bits. An errored write is followed by read-back of both writable registers, and a good access placed right after an error shows that the state machine returns to accepting requests.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [0:0] {
        ST_IDLE     = 1'b0,
        ST_ERR_WAIT = 1'b1
    } bus_state_e;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_OUT  = 3'd1,
        SEL_SET  = 3'd2,
        SEL_IN   = 3'd3,
        SEL_DIR  = 3'd4
    } reg_sel_e;

    localparam logic [7:0] OFS_OUT = 8'h00;
    localparam logic [7:0] OFS_SET = 8'h04;
    localparam logic [7:0] OFS_IN  = 8'h10;
    localparam logic [7:0] OFS_DIR = 8'h14;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NPIN   = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] din,
    output logic [NPIN-1:0] dout
);

    logic [NPIN-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bus_ctrl.sv
module gpio_bus_ctrl
    import gpio_port_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              req_error,
    output logic              wr_out,
    output logic              wr_set,
    output logic              wr_dir,
    output logic              rd_en,
    output reg_sel_e          rd_sel
);

    bus_state_e state_q, state_d;
    reg_sel_e   hit_sel;
    logic       aligned;

    // address decode inside the window
    always_comb begin
        aligned = (req_addr[1:0] == 2'b00);
        hit_sel = SEL_NONE;
        if (aligned) begin
            if      (req_addr == ADDR_W'(OFS_OUT)) hit_sel = SEL_OUT;
            else if (req_addr == ADDR_W'(OFS_SET)) hit_sel = SEL_SET;
            else if (req_addr == ADDR_W'(OFS_IN))  hit_sel = SEL_IN;
            else if (req_addr == ADDR_W'(OFS_DIR)) hit_sel = SEL_DIR;
            else                                   hit_sel = SEL_NONE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && (hit_sel == SEL_NONE)) state_d = ST_ERR_WAIT;
            end
            ST_ERR_WAIT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        req_error = 1'b0;
        wr_out    = 1'b0;
        wr_set    = 1'b0;
        wr_dir    = 1'b0;
        rd_en     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && (hit_sel != SEL_NONE)) begin
                    req_ready = 1'b1;
                    if (req_write) begin
                        wr_out = (hit_sel == SEL_OUT);
                        wr_set = (hit_sel == SEL_SET);
                        wr_dir = (hit_sel == SEL_DIR);
                    end else begin
                        rd_en = 1'b1;
                    end
                end
            end
            ST_ERR_WAIT: begin
                req_ready = 1'b1;
                req_error = 1'b1;
            end
            default: ;
        endcase
    end

    assign rd_sel = hit_sel;

    AST_GOOD_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && hit_sel != SEL_NONE) |-> (req_ready && !req_error)); // R6
    AST_ERR_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && hit_sel == SEL_NONE) |-> !req_ready); // R7
    AST_ERR_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && hit_sel == SEL_NONE) |=> (req_ready && req_error)); // R7
    AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_error |-> req_ready); // R7

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_out,
    input  logic            wr_set,
    input  logic            wr_dir,
    input  logic [NPIN-1:0] wdata,
    input  logic            rd_en,
    input  reg_sel_e        rd_sel,
    input  logic [NPIN-1:0] in_sync,
    output logic [NPIN-1:0] rdata,
    output logic [NPIN-1:0] out_q,
    output logic [NPIN-1:0] dir_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_out) begin
            out_q <= wdata;
        end else if (wr_set) begin
            out_q <= out_q | wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (rd_sel)
                SEL_OUT: rdata = out_q;
                SEL_IN:  rdata = in_sync;
                SEL_DIR: rdata = dir_q;
                default: rdata = '0;
            endcase
        end
    end

    AST_SET_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((out_q & $past(out_q)) == $past(out_q))); // R4
    AST_SET_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_SET) |-> (rdata == '0)); // R4
    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_out || wr_set) |=> $stable(out_q)); // R8
    AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q)); // R8

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned NPIN   = 32,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    output logic              bus_ready,
    output logic              bus_error,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe
);

    localparam int unsigned SYNC_STAGES = 2;

    logic     wr_out, wr_set, wr_dir, rd_en;
    reg_sel_e rd_sel;
    logic [NPIN-1:0] in_sync, out_q, dir_q;

    gpio_bus_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (bus_valid),
        .req_write (bus_write),
        .req_addr  (bus_addr),
        .req_ready (bus_ready),
        .req_error (bus_error),
        .wr_out    (wr_out),
        .wr_set    (wr_set),
        .wr_dir    (wr_dir),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel)
    );

    gpio_in_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (in_sync)
    );

    gpio_regs #(.NPIN(NPIN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_out  (wr_out),
        .wr_set  (wr_set),
        .wr_dir  (wr_dir),
        .wdata   (bus_wdata),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .in_sync (in_sync),
        .rdata   (bus_rdata),
        .out_q   (out_q),
        .dir_q   (dir_q)
    );

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    AST_ERR_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_error |=> ($stable(pad_out) && $stable(pad_oe))); // R8
    AST_ERR_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_error |-> (bus_rdata == '0)); // R7

endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;

    localparam int CLK_PERIOD = 10;
    localparam int NPIN       = 32;
    localparam int ADDR_W     = 6;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [NPIN-1:0]   bus_wdata = '0;
    logic [NPIN-1:0]   bus_rdata;
    logic              bus_ready;
    logic              bus_error;
    logic [NPIN-1:0]   pad_in = '0;
    logic [NPIN-1:0]   pad_out;
    logic [NPIN-1:0]   pad_oe;

    gpio_port #(.NPIN(NPIN), .ADDR_W(ADDR_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .bus_error (bus_error),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [NPIN-1:0] rdata;
        bit              err;
        int              waits;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   wait_cnt = 0;
    bit   done     = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [NPIN-1:0] act,
                         input logic [NPIN-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // monitor: pops one expected item per completed access
    always @(negedge clk) begin
        if (rst_n && bus_valid) begin
            if (bus_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected completion", '0, '0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(bus_rdata == e.rdata, {e.tag, " rdata"}, bus_rdata, e.rdata);
                    check(bus_error == e.err, {e.tag, " error"}, NPIN'(bus_error), NPIN'(e.err));
                    check(wait_cnt == e.waits, {e.tag, " waits"}, NPIN'(wait_cnt), NPIN'(e.waits));
                end
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    // driver: pushes the expectation, then runs the handshake
    task automatic access(input bit wr, input logic [7:0] ofs, input logic [NPIN-1:0] wd,
                          input logic [NPIN-1:0] exp_rd, input bit exp_err, input string tag);
        exp_t e;
        e.rdata = exp_rd;
        e.err   = exp_err;
        e.waits = exp_err ? 1 : 0;
        e.tag   = tag;
        exp_q.push_back(e);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = ofs[ADDR_W-1:0];
        bus_wdata = wd;
        forever begin
            @(negedge clk);
            if (bus_ready) break;
        end
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic wr(input logic [7:0] ofs, input logic [NPIN-1:0] d, input bit err, input string tag);
        access(1'b1, ofs, d, '0, err, tag);
    endtask

    task automatic rd(input logic [7:0] ofs, input logic [NPIN-1:0] expv, input bit err, input string tag);
        access(1'b0, ofs, '0, expv, err, tag);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the pads and through the bus
        check(pad_out == '0, "R1 pad_out after reset", pad_out, '0);
        check(pad_oe == '0, "R1 pad_oe after reset", pad_oe, '0);
        @(posedge clk); #1;
        rd(8'h00, 32'h0, 1'b0, "R1 out reg reset");
        rd(8'h14, 32'h0, 1'b0, "R1 dir reg reset");

        // R2 / R6: output data register
        wr(8'h00, 32'hA5A5_0F0F, 1'b0, "R6 write out");
        rd(8'h00, 32'hA5A5_0F0F, 1'b0, "R2 read out");
        #1 check(pad_out == 32'hA5A5_0F0F, "R2 pad_out", pad_out, 32'hA5A5_0F0F);

        // R3: direction register
        wr(8'h14, 32'hFFFF_0000, 1'b0, "R3 write dir");
        rd(8'h14, 32'hFFFF_0000, 1'b0, "R3 read dir");
        check(pad_oe == 32'hFFFF_0000, "R3 pad_oe", pad_oe, 32'hFFFF_0000);

        // R4: set-output register
        wr(8'h04, 32'h0000_F0F0, 1'b0, "R4 set write");
        rd(8'h00, 32'hA5A5_FFFF, 1'b0, "R4 set result");
        wr(8'h04, 32'h0000_0000, 1'b0, "R4 set zero");
        rd(8'h00, 32'hA5A5_FFFF, 1'b0, "R4 set zero keeps");
        wr(8'h04, 32'h5A00_0000, 1'b0, "R4 set high");
        rd(8'h00, 32'hFFA5_FFFF, 1'b0, "R4 set high result");
        rd(8'h04, 32'h0, 1'b0, "R4 set reads zero");
        check(pad_out == 32'hFFA5_FFFF, "R4 pad_out after set", pad_out, 32'hFFA5_FFFF);

        // R5: two-edge input synchronizer
        pad_in = 32'h1234_5678;
        rd(8'h10, 32'h0, 1'b0, "R5 in before edge");
        rd(8'h10, 32'h0, 1'b0, "R5 in after one edge");
        rd(8'h10, 32'h1234_5678, 1'b0, "R5 in after two edges");
        pad_in = 32'hCAFE_0001;
        repeat (3) @(posedge clk);
        #1;
        rd(8'h10, 32'hCAFE_0001, 1'b0, "R5 in second pattern");
        wr(8'h10, 32'h0000_0000, 1'b0, "R5 write in ignored");
        rd(8'h10, 32'hCAFE_0001, 1'b0, "R5 in unchanged");
        rd(8'h00, 32'hFFA5_FFFF, 1'b0, "R5 out unchanged");
        rd(8'h14, 32'hFFFF_0000, 1'b0, "R5 dir unchanged");

        // R7: error reads
        rd(8'h08, 32'h0, 1'b1, "R7 read 0x08");
        rd(8'h0C, 32'h0, 1'b1, "R7 read 0x0C");
        rd(8'h20, 32'h0, 1'b1, "R7 read 0x20");
        rd(8'h3C, 32'h0, 1'b1, "R7 read 0x3C");
        rd(8'h02, 32'h0, 1'b1, "R7 read misaligned 0x02");
        rd(8'h15, 32'h0, 1'b1, "R7 read misaligned 0x15");
        rd(8'h14, 32'hFFFF_0000, 1'b0, "R6 good after error");

        // R8: errored writes keep state
        wr(8'h08, 32'h1111_1111, 1'b1, "R8 write 0x08");
        wr(8'h01, 32'h0000_0000, 1'b1, "R8 write misaligned out");
        wr(8'h16, 32'h0000_0000, 1'b1, "R8 write misaligned dir");
        wr(8'h05, 32'hFFFF_FFFF, 1'b1, "R8 write misaligned set");
        rd(8'h00, 32'hFFA5_FFFF, 1'b0, "R8 out after error writes");
        rd(8'h14, 32'hFFFF_0000, 1'b0, "R8 dir after error writes");
        check(pad_out == 32'hFFA5_FFFF, "R8 pad_out", pad_out, 32'hFFA5_FFFF);
        check(pad_oe == 32'hFFFF_0000, "R8 pad_oe", pad_oe, 32'hFFFF_0000);

        // R2 / R3: overwrite with a fresh pattern
        wr(8'h00, 32'h0000_0001, 1'b0, "R2 overwrite out");
        wr(8'h14, 32'h8000_0001, 1'b0, "R3 overwrite dir");
        check(pad_out == 32'h0000_0001, "R2 pad_out overwrite", pad_out, 32'h0000_0001);
        check(pad_oe == 32'h8000_0001, "R3 pad_oe overwrite", pad_oe, 32'h8000_0001);

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0)
            check(1'b0, "scoreboard not drained", NPIN'(exp_q.size()), '0);
        done = 1'b1;
        finish_run();
    end

endmodule